// File: doc/BRIEF.md
# Banked GPIO Controller with Per-Pin Modes

This block drives and samples sixteen general-purpose pins through a small word-wide register port. The pins fall into four banks of unequal width: two, four, four and six pins. Each bank has a data word and a configuration word. A single drive-style word, indexed by global pin number, selects push-pull or open-drain output for every pin. Software changes one pin by reading a word, editing the bits and writing the word back. Reads are therefore combinational and have no side effects.

Each pin's direction comes from a four-bit mode code in its bank's configuration word. Only the output code turns on the driver. Every other code leaves the pin undriven and returns the sampled pin level in the data word. In open-drain drive, a stored 1 releases the pin and a stored 0 pulls it low. Pin inputs pass through a two-flop synchroniser before they can be read.

Top module: `gpio_banked_ctrl`

## Requirements
- R1: After reset, and after any later reset, every configuration word and the drive-style word read zero, and pin_oe and pin_out are all zero. The stored data bits are also cleared.
- R2: The bank data words sit at 0x170, 0x174, 0x178 and 0x17C. They serve global pins 0-1, 2-5, 6-9 and 10-15. Bank-local bit n of each word maps to the bank's first pin plus n.
- R3: The bank configuration words sit at 0x180, 0x184, 0x188 and 0x18C. The mode of bank-local pin n is the 4-bit field at bits 4n+3:4n. A write replaces every field of the bank, and a read returns the fields exactly as written.
- R4: A pin whose mode is 0x8 and whose drive bit is 0 has pin_oe=1, and pin_out equals its stored data bit.
- R5: The word at 0x190 holds one drive bit per pin at the global pin's bit position, with bits 31:16 reading zero. When a drive bit is 1 and the mode is 0x8, a stored 0 gives pin_oe=1 and pin_out=0, and a stored 1 gives pin_oe=0. Such a pin never drives pin_out high.
- R6: A data word read returns the stored bit for pins in mode 0x8. For pins in any other mode it returns the synchronised pin level.
- R7: Any mode other than 0x8 (0x1 included) gives pin_oe=0 and pin_out=0. Data writes in such a mode are still stored and appear on the pin once the mode becomes 0x8.
- R8: Data bits and configuration fields above a bank's pin count read zero, and writes to them have no effect.
- R9: Any offset other than the nine listed above reads zero, and a write to it changes no state.
- R10: A change on pin_in shows in a data word read two clock edges later, and not after only one edge.
- R11: Reads leave all state unchanged. Repeated reads return the same value, and the pin outputs stay steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 12 | Byte offset of the register accessed |
| reg_we | input | 1 | Write strobe, taken at the rising edge |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for reg_addr |
| pin_in | input | 16 | Pin levels from the pads |
| pin_out | output | 16 | Level to drive on each pin |
| pin_oe | output | 16 | Driver enable for each pin |

## Verification
The embedded properties check on every cycle that:
- an open-drain pin never drives high;
- an undriven mode never enables a driver;
- undecoded offsets read zero and at most one register decodes;
- each write lands in exactly the targeted word while the other words hold;
- the synchroniser output trails the pins by two edges.

Only the bench's scenarios can show the end-to-end results. These are the per-bank bit packing at each offset, the choice between stored and sampled bits in a mixed-mode bank, data kept across mode changes, the zeroing of bits above each bank's width, and the one-edge versus two-edge read of a pin change.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  localparam int NUM_BANKS = 4;
  localparam int NUM_PINS  = 16;
  localparam int REG_W     = 32;
  localparam int ADDR_W    = 12;
  localparam int MODE_W    = 4;

  localparam logic [ADDR_W-1:0] DATA_BASE  = 12'h170;
  localparam logic [ADDR_W-1:0] CFG_BASE   = 12'h180;
  localparam logic [ADDR_W-1:0] DRIVE_ADDR = 12'h190;
  localparam int                ADDR_STEP  = 4;

  localparam logic [MODE_W-1:0] MODE_INPUT  = 4'h1;
  localparam logic [MODE_W-1:0] MODE_OUTPUT = 4'h8;

  // pins held by each bank
  function automatic int bank_width(input int b);
    case (b)
      0:       return 2;
      1:       return 4;
      2:       return 4;
      default: return 6;
    endcase
  endfunction

  // global index of a bank's pin 0
  function automatic int bank_first(input int b);
    int acc;
    acc = 0;
    for (int k = 0; k < b; k++) acc += bank_width(k);
    return acc;
  endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] meta_q;
  logic [WIDTH-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= din;
      sync_q <= meta_q;
    end
  end

  assign dout = sync_q;

  // edges seen since reset, saturating at two, for the delay check
  logic [1:0] warm_q;
  logic [1:0] warm_d;

  always_comb begin
    warm_d = warm_q;
    if (warm_q != 2'd2) warm_d = warm_q + 2'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) warm_q <= 2'd0;
    else        warm_q <= warm_d;
  end

  AST_SYNC_TWO_EDGES: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_q == 2'd2) |-> (dout == $past(din, 2)));  // R10

endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
  import gpio_bank_pkg::*;
#(
  parameter int                WIDTH     = 2,
  parameter logic [ADDR_W-1:0] DATA_ADDR = 12'h170,
  parameter logic [ADDR_W-1:0] CFG_ADDR  = 12'h180
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [MODE_W*WIDTH-1:0]  wr_data,
  input  logic [WIDTH-1:0]         pin_sync,
  output logic                     rd_hit,
  output logic [REG_W-1:0]         rd_val,
  output logic [WIDTH-1:0]         drv_level,
  output logic [WIDTH-1:0]         drv_active
);

  localparam int CFG_W = MODE_W * WIDTH;

  logic             data_sel;
  logic             cfg_sel;
  logic             data_en;
  logic             cfg_en;
  logic [WIDTH-1:0] data_d;
  logic [WIDTH-1:0] data_q;
  logic [CFG_W-1:0] cfg_d;
  logic [CFG_W-1:0] cfg_q;
  logic [WIDTH-1:0] rd_bits;

  assign data_sel = (addr == DATA_ADDR);
  assign cfg_sel  = (addr == CFG_ADDR);
  assign rd_hit   = data_sel | cfg_sel;

  // next-state
  always_comb begin
    data_en = wr_en & data_sel;
    cfg_en  = wr_en & cfg_sel;
    data_d  = wr_data[WIDTH-1:0];
    cfg_d   = wr_data;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      cfg_q  <= '0;
    end else begin
      if (data_en) data_q <= data_d;
      if (cfg_en)  cfg_q  <= cfg_d;
    end
  end

  // per-pin mode decode and readback selection
  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    logic [MODE_W-1:0] mode;
    logic              is_out;
    assign mode          = cfg_q[MODE_W*i +: MODE_W];
    assign is_out        = (mode == MODE_OUTPUT);
    assign drv_active[i] = is_out;
    assign drv_level[i]  = data_q[i];
    assign rd_bits[i]    = is_out ? data_q[i] : pin_sync[i];
  end

  always_comb begin
    rd_val = '0;
    if (data_sel)     rd_val[WIDTH-1:0] = rd_bits;
    else if (cfg_sel) rd_val[CFG_W-1:0] = cfg_q;
  end

  AST_CFG_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == CFG_ADDR) |=> (cfg_q == $past(wr_data)));  // R3

  AST_CFG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr == CFG_ADDR) |=> $stable(cfg_q));  // R11

  AST_DATA_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr == DATA_ADDR) |=> $stable(data_q));  // R9

endmodule

// File: rtl/gpio_drive_ctl.sv
module gpio_drive_ctl
  import gpio_bank_pkg::*;
#(
  parameter int PINS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [PINS-1:0]   wr_data,
  input  logic [PINS-1:0]   level,
  input  logic [PINS-1:0]   active,
  output logic              rd_hit,
  output logic [REG_W-1:0]  rd_val,
  output logic [PINS-1:0]   pin_out,
  output logic [PINS-1:0]   pin_oe
);

  logic            sel;
  logic            od_en;
  logic [PINS-1:0] od_d;
  logic [PINS-1:0] od_q;

  assign sel    = (addr == DRIVE_ADDR);
  assign rd_hit = sel;

  always_comb begin
    od_en = wr_en & sel;
    od_d  = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     od_q <= '0;
    else if (od_en) od_q <= od_d;
  end

  always_comb begin
    rd_val = '0;
    if (sel) rd_val[PINS-1:0] = od_q;
  end

  // push-pull drives both levels; open-drain only pulls low
  for (genvar i = 0; i < PINS; i++) begin : g_drv
    always_comb begin
      pin_out[i] = 1'b0;
      pin_oe[i]  = 1'b0;
      if (active[i]) begin
        if (od_q[i]) begin
          pin_oe[i] = ~level[i];
        end else begin
          pin_oe[i]  = 1'b1;
          pin_out[i] = level[i];
        end
      end
    end
  end

  AST_OD_NEVER_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    ((pin_out & pin_oe & od_q) == '0));  // R5

  AST_DRIVE_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == DRIVE_ADDR) |=> (od_q == $past(wr_data)));  // R5

endmodule

// File: rtl/gpio_banked_ctrl.sv
module gpio_banked_ctrl
  import gpio_bank_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic                reg_we,
  input  logic [REG_W-1:0]    reg_wdata,
  output logic [REG_W-1:0]    reg_rdata,
  input  logic [NUM_PINS-1:0] pin_in,
  output logic [NUM_PINS-1:0] pin_out,
  output logic [NUM_PINS-1:0] pin_oe
);

  logic [NUM_PINS-1:0]  pin_sync;
  logic [NUM_PINS-1:0]  all_level;
  logic [NUM_PINS-1:0]  all_active;
  logic [NUM_BANKS-1:0] bank_hit;
  logic [REG_W-1:0]     bank_rd [NUM_BANKS];
  logic                 drv_hit;
  logic [REG_W-1:0]     drv_rd;

  gpio_in_sync #(.WIDTH(NUM_PINS)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (pin_in),
    .dout (pin_sync)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam int W     = bank_width(b);
    localparam int FIRST = bank_first(b);
    localparam logic [ADDR_W-1:0] D_ADDR = DATA_BASE + ADDR_W'(ADDR_STEP * b);
    localparam logic [ADDR_W-1:0] C_ADDR = CFG_BASE  + ADDR_W'(ADDR_STEP * b);

    gpio_bank_regs #(
      .WIDTH    (W),
      .DATA_ADDR(D_ADDR),
      .CFG_ADDR (C_ADDR)
    ) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (reg_we),
      .addr      (reg_addr),
      .wr_data   (reg_wdata[MODE_W*W-1:0]),
      .pin_sync  (pin_sync[FIRST +: W]),
      .rd_hit    (bank_hit[b]),
      .rd_val    (bank_rd[b]),
      .drv_level (all_level[FIRST +: W]),
      .drv_active(all_active[FIRST +: W])
    );
  end

  gpio_drive_ctl #(.PINS(NUM_PINS)) u_drive (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (reg_we),
    .addr   (reg_addr),
    .wr_data(reg_wdata[NUM_PINS-1:0]),
    .level  (all_level),
    .active (all_active),
    .rd_hit (drv_hit),
    .rd_val (drv_rd),
    .pin_out(pin_out),
    .pin_oe (pin_oe)
  );

  // at most one source decodes, so an OR tree is the read mux
  always_comb begin
    reg_rdata = drv_rd;
    for (int b = 0; b < NUM_BANKS; b++) reg_rdata |= bank_rd[b];
  end

  logic unused_wdata_hi;
  assign unused_wdata_hi = ^reg_wdata[REG_W-1:MODE_W*bank_width(NUM_BANKS-1)];

  AST_ONE_DECODE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({drv_hit, bank_hit}));  // R2

  AST_UNDECODED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !(drv_hit || (|bank_hit)) |-> (reg_rdata == '0));  // R9

  AST_IDLE_MODE_UNDRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
    ((pin_oe & ~all_active) == '0) && ((pin_out & ~all_active) == '0));  // R7

endmodule

// File: tb/gpio_banked_ctrl_bench.sv
module gpio_banked_ctrl_bench;

  typedef struct packed {
    logic        we;
    logic [11:0] addr;
    logic [31:0] wdata;
    logic [31:0] rd;
    logic [15:0] oe;
    logic [15:0] out;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 14;
  localparam logic [15:0] PINS0 = 16'hA5C3;

  // pins held at PINS0 throughout the table
  localparam vec_t VECS [NV] = '{
    '{1'b1, 12'h180, 32'hFFFF_FF88, 32'h0000_0088, 16'h0003, 16'h0000, 4'd8},  // R3 R8 bank0 outputs
    '{1'b1, 12'h170, 32'hFFFF_FFFE, 32'h0000_0002, 16'h0003, 16'h0002, 4'd4},  // R2 R4 R8
    '{1'b1, 12'h190, 32'hFFFF_0002, 32'h0000_0002, 16'h0001, 16'h0000, 4'd5},  // R5 pin1 released
    '{1'b1, 12'h170, 32'h0000_0001, 32'h0000_0001, 16'h0003, 16'h0001, 4'd5},  // R5 pin1 pulled low
    '{1'b1, 12'h18C, 32'h0081_8F18, 32'h0081_8F18, 16'hA403, 16'h0001, 4'd3},  // R3 mixed modes
    '{1'b1, 12'h17C, 32'hFFFF_FFFF, 32'h0000_0029, 16'hA403, 16'hA401, 4'd6},  // R6 mixed readback
    '{1'b0, 12'h178, 32'h0000_0000, 32'h0000_0007, 16'hA403, 16'hA401, 4'd6},  // R6 sampled pins
    '{1'b1, 12'h100, 32'hFFFF_FFFF, 32'h0000_0000, 16'hA403, 16'hA401, 4'd9},  // R9 undecoded write
    '{1'b1, 12'h184, 32'h0000_2481, 32'h0000_2481, 16'hA40B, 16'hA401, 4'd7},  // R7 odd codes
    '{1'b1, 12'h174, 32'h0000_000F, 32'h0000_0002, 16'hA40B, 16'hA409, 4'd6},  // R6
    '{1'b1, 12'h184, 32'h0000_0000, 32'h0000_0000, 16'hA403, 16'hA401, 4'd7},  // R7 driver off
    '{1'b1, 12'h184, 32'h0000_0080, 32'h0000_0080, 16'hA40B, 16'hA409, 4'd7},  // R7 data kept
    '{1'b0, 12'h194, 32'h0000_0000, 32'h0000_0000, 16'hA40B, 16'hA409, 4'd9},  // R9 undecoded read
    '{1'b1, 12'h190, 32'h0000_8002, 32'h0000_8002, 16'h240B, 16'h2409, 4'd5}   // R5 pin15 released
  };

  logic        clk;
  logic        rst_n;
  logic [11:0] reg_addr;
  logic        reg_we;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic [15:0] pin_in;
  logic [15:0] pin_out;
  logic [15:0] pin_oe;

  int n_checks;
  int n_fails;
  bit done;

  gpio_banked_ctrl u_gpio_banked_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_addr (reg_addr),
    .reg_we   (reg_we),
    .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata),
    .pin_in   (pin_in),
    .pin_out  (pin_out),
    .pin_oe   (pin_oe)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic read_at(input logic [11:0] a, input string tag, input logic [31:0] exp);
    reg_we   = 1'b0;
    reg_addr = a;
    #1;
    check(tag, reg_rdata, exp);
  endtask

  initial begin
    n_checks  = 0;
    n_fails   = 0;
    done      = 1'b0;
    rst_n     = 1'b0;
    reg_we    = 1'b0;
    reg_addr  = '0;
    reg_wdata = '0;
    pin_in    = PINS0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state, R2 data words carry synchronised pins
    check("R1 oe", {16'h0, pin_oe}, 32'h0);
    check("R1 out", {16'h0, pin_out}, 32'h0);
    read_at(12'h180, "R1 cfg0", 32'h0);
    read_at(12'h184, "R1 cfg1", 32'h0);
    read_at(12'h188, "R1 cfg2", 32'h0);
    read_at(12'h18C, "R1 cfg3", 32'h0);
    read_at(12'h190, "R1 drive", 32'h0);
    read_at(12'h170, "R2 data0", 32'h3);
    read_at(12'h174, "R2 data1", 32'h0);
    read_at(12'h178, "R2 data2", 32'h7);
    read_at(12'h17C, "R2 data3", 32'h29);

    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      reg_we    = VECS[v].we;
      reg_addr  = VECS[v].addr;
      reg_wdata = VECS[v].wdata;
      @(posedge clk);
      #2;
      check($sformatf("R%0d vec%0d rdata", VECS[v].req, v), reg_rdata, VECS[v].rd);
      check($sformatf("R%0d vec%0d oe", VECS[v].req, v), {16'h0, pin_oe}, {16'h0, VECS[v].oe});
      check($sformatf("R%0d vec%0d out", VECS[v].req, v), {16'h0, pin_out}, {16'h0, VECS[v].out});
    end
    @(negedge clk);
    reg_we = 1'b0;

    // R8 upper fields of bank 0 stayed clear after all-ones writes
    read_at(12'h180, "R8 cfg0 upper", 32'h88);

    // R10 pin 6 falls: old level after one edge, new level after two
    @(negedge clk);
    reg_addr  = 12'h178;
    pin_in[6] = 1'b0;
    @(posedge clk);
    #2;
    check("R10 one edge", reg_rdata, 32'h7);
    @(posedge clk);
    #2;
    check("R10 two edges", reg_rdata, 32'h6);

    // R11 repeated reads change nothing
    @(negedge clk);
    reg_addr = 12'h18C;
    repeat (4) begin
      @(posedge clk);
      #2;
      check("R11 cfg3 repeat", reg_rdata, 32'h0081_8F18);
      check("R11 oe steady", {16'h0, pin_oe}, 32'h240B);
    end

    // R1 reset again mid-run
    @(negedge clk);
    rst_n = 1'b0;
    #2;
    check("R1 re-reset oe", {16'h0, pin_oe}, 32'h0);
    read_at(12'h18C, "R1 re-reset cfg3", 32'h0);
    read_at(12'h190, "R1 re-reset drive", 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    reg_we    = 1'b1;
    reg_addr  = 12'h180;
    reg_wdata = 32'h8;
    @(negedge clk);
    reg_we = 1'b0;
    #1;
    check("R1 data cleared oe", {16'h0, pin_oe}, 32'h1);
    check("R1 data cleared out", {16'h0, pin_out}, 32'h0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end

endmodule